// File: doc/BRIEF.md
# Boot Image Validity Checker

After every reset this block checks the first page of program flash before the processor may leave reset. It walks the page one 32-bit word at a time through a synchronous read port. The port returns data one cycle after each request. The block adds up every word except the reserved word at byte address 0x14, and it keeps that reserved word separately.

Once the whole page has been read, the block accepts the image in either of two cases: the reserved word holds the fixed marker 0x27011970, or it equals the computed sum. If the image is accepted, the block raises `run_user` so the core may fetch user code. Otherwise it raises `enter_download`, and the system falls back to loading an image over a serial link. `done` marks the end of the check. The result stays unchanged until the next reset.

Top module: `boot_image_checker`

## Requirements
- R1: While `rst_n` is low, `done`, `run_user`, `enter_download` and `rd_en` are all low.
- R2: After reset is released, the block reads every word of the page exactly once. It issues byte addresses 0, 4, 8, … up to PAGE_BYTES-4 on consecutive cycles. `rd_addr` bits [1:0] are always zero. `rd_data` is taken one cycle after the cycle in which `rd_en` is high.
- R3: If the word at byte address 0x14 equals 0x27011970, the verdict is `run_user`=1 and `enter_download`=0.
- R4: If the word at 0x14 equals the 32-bit sum, modulo 2^32, of all other page words, the verdict is `run_user`=1. Carries out of bit 31 are discarded.
- R5: If the word at 0x14 matches neither the marker nor the sum, the verdict is `enter_download`=1 and `run_user`=0.
- R6: The word at 0x14 never contributes to the sum.
- R7: `run_user` and `enter_download` are never high together, and both stay low while `done` is low.
- R8: `done` rises on the rising edge numbered PAGE_BYTES/4+3, counting the first rising edge with `rst_n` high as number 1. After that, `done`, `run_user` and `enter_download` hold their values and `rd_en` stays low until the next reset.
- R9: A reset in the middle of a check clears all outputs at once. After reset is released again, a complete new check runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; releasing it starts a check |
| rd_en | output | 1 | Read request to flash |
| rd_addr | output | $clog2(PAGE_BYTES) | Byte address of the requested word |
| rd_data | input | 32 | Flash word, valid one cycle after `rd_en` |
| done | output | 1 | Check finished; held until reset |
| run_user | output | 1 | Image accepted; core may run user code |
| enter_download | output | 1 | Image rejected; enter serial download mode |

## Verification
Two acceptance paths can hold in the same cycle: the marker test and the checksum test. They collide when the other page words happen to sum to the marker value itself. The bench builds such a page by adjusting word 0 until the non-reserved sum equals 0x27011970, and it places the marker at 0x14. The result must be a single `run_user` with `enter_download` low. A second page has a non-reserved sum of zero and reserved word 1. It is accepted only if the reserved word is wrongly added into the sum, so it must be rejected.

// File: rtl/boot_chk_pkg.sv
package boot_chk_pkg;

  localparam logic [31:0] BOOT_MARKER   = 32'h2701_1970;
  localparam int unsigned RESV_BYTE_ADR = 32'h14;
  localparam int unsigned RESV_WORD_IDX = RESV_BYTE_ADR / 4;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_READ    = 2'd1,
    ST_COMPARE = 2'd2,
    ST_DONE    = 2'd3
  } boot_st_e;

  // one accumulation step of the page checksum (modulo 2^32)
  function automatic logic [31:0] csum_step(input logic [31:0] acc,
                                            input logic [31:0] word);
    return acc + word;
  endfunction

  function automatic logic is_marker(input logic [31:0] resv);
    return resv == BOOT_MARKER;
  endfunction

  function automatic logic page_accept(input logic [31:0] resv,
                                       input logic [31:0] sum);
    return is_marker(resv) || (resv == sum);
  endfunction

endpackage

// File: rtl/boot_rd_seq.sv
module boot_rd_seq #(
  parameter int unsigned WORDS = 128,
  parameter int unsigned IW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  output logic          rd_en,
  output logic [IW-1:0] rd_idx,
  output logic          last_issue,
  output logic          beat_vld,
  output logic [IW-1:0] beat_idx
);

  logic [IW-1:0] idx_q;

  assign rd_en      = run;
  assign rd_idx     = idx_q;
  assign last_issue = run && (idx_q == IW'(WORDS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q    <= '0;
      beat_vld <= 1'b0;
      beat_idx <= '0;
    end else begin
      beat_vld <= run;
      beat_idx <= idx_q;
      if (run && !last_issue) idx_q <= idx_q + 1'b1;
    end
  end

  // consecutive requests step by one word
  assert_idx_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(rd_en)) |-> (rd_idx == $past(rd_idx) + 1'b1));

  // a burst of requests begins at the start of the page
  assert_first_idx_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_en) |-> (rd_idx == '0));

  // each returned beat carries the index that was requested
  assert_beat_tag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (beat_vld && beat_idx == $past(rd_idx)));

endmodule

// File: rtl/boot_csum_acc.sv
module boot_csum_acc #(
  parameter int unsigned IW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          beat_vld,
  input  logic [IW-1:0] beat_idx,
  input  logic [31:0]   beat_data,
  output logic [31:0]   sum_q,
  output logic [31:0]   resv_q,
  output logic          beat_is_resv
);
  import boot_chk_pkg::*;

  assign beat_is_resv = beat_vld && (beat_idx == IW'(RESV_WORD_IDX));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum_q  <= '0;
      resv_q <= '0;
    end else if (beat_vld) begin
      if (beat_is_resv) resv_q <= beat_data;
      else              sum_q  <= csum_step(sum_q, beat_data);
    end
  end

  // the reserved beat leaves the running sum untouched
  assert_resv_excluded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    beat_is_resv |=> (sum_q == $past(sum_q)));

  // without a beat nothing moves
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_vld |=> ($stable(sum_q) && $stable(resv_q)));

endmodule

// File: rtl/boot_verdict.sv
module boot_verdict (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        decide,
  input  logic [31:0] sum_in,
  input  logic [31:0] resv_in,
  output logic        match_marker,
  output logic        match_sum,
  output logic        done,
  output logic        run_user,
  output logic        enter_download
);
  import boot_chk_pkg::*;

  logic accept;

  assign match_marker = is_marker(resv_in);
  assign match_sum    = (resv_in == sum_in);
  assign accept       = page_accept(resv_in, sum_in);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done           <= 1'b0;
      run_user       <= 1'b0;
      enter_download <= 1'b0;
    end else if (decide && !done) begin
      done           <= 1'b1;
      run_user       <= accept;
      enter_download <= !accept;
    end
  end

  assert_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(run_user && enter_download));

  assert_gated_by_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_user || enter_download) |-> done);

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && $stable(run_user) && $stable(enter_download)));

  assert_one_verdict_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (run_user != enter_download));

  // either match path alone is enough to accept
  assert_either_path_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && !done && (match_marker || match_sum)) |=> run_user);

endmodule

// File: rtl/boot_image_checker.sv
module boot_image_checker #(
  parameter int unsigned PAGE_BYTES = 512
) (
  input  logic                          clk,
  input  logic                          rst_n,
  output logic                          rd_en,
  output logic [$clog2(PAGE_BYTES)-1:0] rd_addr,
  input  logic [31:0]                   rd_data,
  output logic                          done,
  output logic                          run_user,
  output logic                          enter_download
);
  import boot_chk_pkg::*;

  localparam int unsigned AW    = $clog2(PAGE_BYTES);
  localparam int unsigned IW    = AW - 2;
  localparam int unsigned WORDS = PAGE_BYTES / 4;

  boot_st_e      st_q, st_d;
  logic          seq_run;
  logic [IW-1:0] rd_idx;
  logic          last_issue;
  logic          beat_vld;
  logic [IW-1:0] beat_idx;
  logic [31:0]   sum_q;
  logic [31:0]   resv_q;
  logic          beat_is_resv;
  logic          decide;
  logic          match_marker;
  logic          match_sum;

  assign seq_run = (st_q == ST_READ);
  assign decide  = (st_q == ST_COMPARE) && !beat_vld;
  assign rd_addr = {rd_idx, 2'b00};

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:    st_d = ST_READ;
      ST_READ:    if (last_issue) st_d = ST_COMPARE;
      ST_COMPARE: if (!beat_vld)  st_d = ST_DONE;
      ST_DONE:    st_d = ST_DONE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  boot_rd_seq #(.WORDS(WORDS), .IW(IW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (seq_run),
    .rd_en      (rd_en),
    .rd_idx     (rd_idx),
    .last_issue (last_issue),
    .beat_vld   (beat_vld),
    .beat_idx   (beat_idx)
  );

  boot_csum_acc #(.IW(IW)) u_acc (
    .clk          (clk),
    .rst_n        (rst_n),
    .beat_vld     (beat_vld),
    .beat_idx     (beat_idx),
    .beat_data    (rd_data),
    .sum_q        (sum_q),
    .resv_q       (resv_q),
    .beat_is_resv (beat_is_resv)
  );

  boot_verdict u_vrd (
    .clk            (clk),
    .rst_n          (rst_n),
    .decide         (decide),
    .sum_in         (sum_q),
    .resv_in        (resv_q),
    .match_marker   (match_marker),
    .match_sum      (match_sum),
    .done           (done),
    .run_user       (run_user),
    .enter_download (enter_download)
  );

  assert_no_read_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rd_en);

  assert_addr_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (rd_addr[1:0] == 2'b00));

  assert_no_beat_when_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!beat_vld && !beat_is_resv));

  assert_reset_clears_R1: assert property (@(posedge clk)
    $past(!rst_n) |-> (!done && !run_user && !enter_download));

endmodule

// File: tb/tb_boot_image_checker.sv
`timescale 1ns/1ps
module tb_boot_image_checker;

  localparam int unsigned PAGE_BYTES = 512;
  localparam int unsigned AW         = $clog2(PAGE_BYTES);
  localparam int unsigned WORDS      = PAGE_BYTES / 4;
  localparam int unsigned RESV       = 5;
  localparam logic [31:0] MARKER     = 32'h2701_1970;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_en;
  logic [AW-1:0] rd_addr;
  logic [31:0]   rd_data = '0;
  logic          done, run_user, enter_download;

  logic [31:0] mem [WORDS];
  int          rd_cnt [WORDS];
  int          misaligned = 0;
  int          order_err = 0;
  int          next_adr = 0;
  int          checks = 0;
  int          errors = 0;

  always #2 clk = ~clk;

  boot_image_checker #(.PAGE_BYTES(PAGE_BYTES)) dut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .done(done), .run_user(run_user),
    .enter_download(enter_download)
  );

  // flash model: one cycle read latency
  always @(posedge clk) begin
    if (rd_en) begin
      rd_data <= mem[rd_addr >> 2];
      rd_cnt[rd_addr >> 2] = rd_cnt[rd_addr >> 2] + 1;
      if (rd_addr[1:0] != 2'b00) misaligned = misaligned + 1;
      if (int'(rd_addr) != next_adr) order_err = order_err + 1;
      next_adr = int'(rd_addr) + 4;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rest_sum();
    logic [31:0] s = '0;
    for (int i = 0; i < WORDS; i++) if (i != RESV) s = s + mem[i];
    return s;
  endfunction

  task automatic fill(input logic [31:0] seed);
    for (int i = 0; i < WORDS; i++) mem[i] = (i * 32'h9E37_79B9) ^ seed;
  endtask

  // force the non-reserved sum to a target by adjusting word 0
  task automatic set_rest_sum(input logic [31:0] target);
    mem[0] = mem[0] + (target - rest_sum());
  endtask

  task automatic run_page(input bit exp_run, input string req);
    int  n = 0;
    bit  early = 0;
    bit  stable = 1;
    int  bad_cnt = 0;
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    check(!done && !run_user && !enter_download && !rd_en, "R1",
          {done, run_user, enter_download, rd_en}, 0);
    for (int i = 0; i < WORDS; i++) rd_cnt[i] = 0;
    misaligned = 0; order_err = 0; next_adr = 0;
    rst_n = 1'b1;
    while (!done && n < WORDS + 40) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (!done && (run_user || enter_download)) early = 1;
    end
    check(!early, "R7", early, 0);
    check(n == WORDS + 3, "R8", n, WORDS + 3);
    check(run_user == exp_run, req, run_user, exp_run);
    check(enter_download == !exp_run, req, enter_download, !exp_run);
    check(!(run_user && enter_download), "R7", {run_user, enter_download}, 0);
    for (int i = 0; i < WORDS; i++) if (rd_cnt[i] != 1) bad_cnt++;
    check(bad_cnt == 0, "R2", bad_cnt, 0);
    check(misaligned == 0 && order_err == 0, "R2", misaligned + order_err, 0);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (!done || rd_en || run_user != exp_run || enter_download != !exp_run) stable = 0;
    end
    check(stable, "R8", stable, 1);
  endtask

  task automatic t_marker();
    fill(32'h1357_2468); mem[RESV] = MARKER;
    if (rest_sum() == MARKER) mem[1] = mem[1] + 1;
    run_page(1'b1, "R3");
  endtask

  task automatic t_sum();
    fill(32'hA5A5_0001); mem[RESV] = rest_sum();
    run_page(1'b1, "R4");
  endtask

  task automatic t_sum_wrap();
    for (int i = 0; i < WORDS; i++) mem[i] = 32'hFFFF_FFF0;
    mem[RESV] = rest_sum();   // heavy carry loss
    run_page(1'b1, "R4");
  endtask

  task automatic t_bad();
    fill(32'h0BAD_F00D); mem[RESV] = rest_sum() + 32'd1;
    run_page(1'b0, "R5");
  endtask

  task automatic t_resv_excluded();
    fill(32'h7777_0000); set_rest_sum(32'd0); mem[RESV] = 32'd1;
    run_page(1'b0, "R6");
  endtask

  task automatic t_both_match();
    fill(32'h2222_3333); set_rest_sum(MARKER); mem[RESV] = MARKER;
    run_page(1'b1, "R3");
  endtask

  task automatic t_mid_reset();
    fill(32'h0BAD_0BAD); mem[RESV] = 32'h0;
    if (rest_sum() == 32'h0) mem[1] = mem[1] + 1;
    rst_n = 1'b0; @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    repeat (WORDS / 2) @(negedge clk);
    check(rd_en && !done, "R9", {rd_en, done}, 2'b10);
    rst_n = 1'b0;
    @(negedge clk);
    check(!done && !run_user && !enter_download && !rd_en, "R9",
          {done, run_user, enter_download, rd_en}, 0);
    mem[RESV] = rest_sum();
    run_page(1'b1, "R9");
  endtask

  initial begin
    #(4 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < WORDS; i++) begin mem[i] = '0; rd_cnt[i] = 0; end
    t_marker();
    t_sum();
    t_sum_wrap();
    t_bad();
    t_resv_excluded();
    t_both_match();
    t_mid_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule